// File: doc/BRIEF.md
# Serial Transceiver Control Port

This block is the host-side control and status port of a line transceiver. A host drives a chip select, a serial clock and a data line. The block runs from a fast system clock and oversamples those pins. Each access is a 16-bit transfer made of a command byte and then a data byte, both sent least significant bit first. A write loads one 8-bit control register. That register holds the equalizer code, the loopback and all-ones enables, and two alarm clear bits. A read returns the register, except that its top three bits are replaced by an encoded status.

The port also watches two alarm inputs: loss of signal and driver failure. Any change of either alarm is latched. The latch pulls an active-low interrupt down until the host clears it. A write that asks for both loopbacks at once is not a mode. It is a reset command: it zeroes the register and raises a one-cycle reset pulse for the rest of the transceiver.

The serial data output is three-state. It is modelled as a data bit plus an output enable. The system clock must run at least 8 times faster than the serial clock.

Top module: `xcp_ctrl_port`

## Requirements
- R1: Command byte bit 0 selects the direction (1 = read, 0 = write) and command bit 5 selects the device. A transfer with command bit 5 clear changes no output and never enables SDO.
- R2: A selected write takes effect when its 16th bit arrives. Data bits 4:2 drive `eq_code_o`, bit 5 the remote loopback, bit 6 the local loopback and bit 7 the all-ones request. A transfer ended by CS rising before 16 bits changes nothing.
- R3: `taos_o` is low whenever `rloop_o` is high, whatever the stored all-ones bit.
- R4: A write with data bits 5 and 6 both set clears every register bit and both alarm latches, releases the interrupt, and pulses `rst_cmd_o` high for exactly one cycle.
- R5: A selected read returns bits 4:0 of the stored register unchanged, in data bits 4:0.
- R6: Read data bits 7:5 carry a status code. Any alarm change wins: code 1,L,D, with L the loss-of-signal latch and D the driver latch. Next comes remote loopback (100). Otherwise the code is 0, then local loopback, then all-ones (so 000 after reset).
- R7: With `clke_i` low, each read bit is launched on a rising SCLK edge and is valid at the next falling edge. With `clke_i` high, each bit is launched on a falling edge and is valid at the next rising edge.
- R8: `sdo_oe_o` is low while CS is high, during any write and during any unselected transfer.
- R9: A change of level on `los_i` or `dpm_i` sets its latch and drives `irq_no` low. The interrupt stays low until the latches are cleared.
- R10: Write data bit 0 clears the loss-of-signal latch and bit 1 clears the driver latch. Each clear takes effect only if that alarm input is low at the time.
- R11: After reset all control outputs are 0, `irq_no` is 1, `sdo_oe_o` is 0 and `rst_cmd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in, sampled on rising SCLK |
| clke_i | input | 1 | Selects the SDO launch edge |
| los_i | input | 1 | Loss-of-signal alarm level |
| dpm_i | input | 1 | Driver failure alarm level |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | SDO drive enable (0 = high impedance) |
| irq_no | output | 1 | Interrupt, active low (open-drain pull) |
| eq_code_o | output | 3 | Equalizer code |
| rloop_o | output | 1 | Remote loopback enable |
| lloop_o | output | 1 | Local loopback enable |
| taos_o | output | 1 | Transmit all-ones enable (gated) |
| rst_cmd_o | output | 1 | One-cycle reset command pulse |

## Verification
A wrong bit count or a wrong command capture shows at the control outputs within a few system clocks after the 16th SCLK rise. It appears either as a committed field in the wrong place or as an aborted frame that still commits. A stale or misordered status code is visible on the first read after an alarm or mode change, in SDO bits 7:5. A broken alarm latch shows on `irq_no`, about three system clocks after the alarm pin moves or after the clearing write ends.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
  localparam int EQ_W  = 3;
  localparam int CMD_W = 8;
  localparam int RW_BIT  = 0;
  localparam int SEL_BIT = 5;

  typedef struct packed {
    logic            taos;
    logic            lloop;
    logic            rloop;
    logic [EQ_W-1:0] eq;
    logic            clr_dpm;
    logic            clr_los;
  } ctrl_reg_t;

  localparam int DAT_W = $bits(ctrl_reg_t);

  // alarm changes outrank every mode
  function automatic logic [2:0] status_code(input logic los_chg, input logic dpm_chg,
                                             input logic rloop, input logic lloop,
                                             input logic taos);
    if (los_chg || dpm_chg) return {1'b1, los_chg, dpm_chg};
    else if (rloop)         return 3'b100;
    else                    return {1'b0, lloop, taos};
  endfunction
endpackage

// File: rtl/xcp_sync.sv
module xcp_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain[0] <= RST_VAL;
    else         chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else         chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xcp_edge.sv
module xcp_edge #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/xcp_frame.sv
module xcp_frame
  import xcp_pkg::*;
#(
  parameter int CW   = CMD_W,
  parameter int DW   = DAT_W,
  parameter int RWB  = RW_BIT,
  parameter int SELB = SEL_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sdi_i,
  input  logic          clke_i,
  input  logic [DW-1:0] rd_byte_i,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int FRAME_W = CW + DW;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(DW);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             rw_q, sel_q;
  logic [DW-2:0]    dat_q;
  logic [DW-1:0]    rd_sh;
  logic             shift_en, rd_go, in_data;
  logic [IDX_W-1:0] idx_r, idx_f;

  assign shift_en = sclk_rise_i & active & ~cs_i & (cnt < CNT_W'(FRAME_W));
  assign in_data  = (cnt >= CNT_W'(CW)) & (cnt < CNT_W'(FRAME_W - 1));
  // bit launched on rising edge leads the capture count by one
  assign idx_r    = IDX_W'(cnt - CNT_W'(CW - 1));
  assign idx_f    = IDX_W'(cnt - CNT_W'(CW));
  assign rd_go    = shift_en & (cnt == CNT_W'(CW - 1)) & rw_q & sel_q;
  assign wr_stb_o = shift_en & (cnt == CNT_W'(FRAME_W - 1)) & ~rw_q & sel_q;
  assign wr_data_o = {sdi_i, dat_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active   <= 1'b0;
      cnt      <= '0;
      rw_q     <= 1'b0;
      sel_q    <= 1'b0;
      dat_q    <= '0;
      rd_sh    <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (cs_fall_i) begin
      active   <= 1'b1;
      cnt      <= '0;
      rw_q     <= 1'b0;
      sel_q    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (cs_i || cs_rise_i) begin
      active   <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (shift_en) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(RWB))  rw_q  <= sdi_i;
        if (cnt == CNT_W'(SELB)) sel_q <= sdi_i;
        if (in_data) dat_q[idx_f] <= sdi_i;
        if (rd_go) begin
          rd_sh    <= rd_byte_i;
          sdo_oe_o <= 1'b1;
          if (!clke_i) sdo_o <= rd_byte_i[0];
        end else if (sdo_oe_o && !clke_i && cnt < CNT_W'(FRAME_W - 1)) begin
          sdo_o <= rd_sh[idx_r];
        end
      end
      if (sclk_fall_i && sdo_oe_o && clke_i && cnt >= CNT_W'(CW) && cnt < CNT_W'(FRAME_W))
        sdo_o <= rd_sh[idx_f];
    end
  end
endmodule

// File: rtl/xcp_regs.sv
module xcp_regs
  import xcp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_stb_i,
  input  ctrl_reg_t  wr_data_i,
  input  logic       los_i,
  input  logic       dpm_i,
  input  logic       los_tog_i,
  input  logic       dpm_tog_i,
  output ctrl_reg_t  ctrl_o,
  output logic       los_chg_o,
  output logic       dpm_chg_o,
  output logic       rst_cmd_o
);
  logic reset_req, clr_los_ok, clr_dpm_ok;

  assign reset_req  = wr_stb_i & wr_data_i.rloop & wr_data_i.lloop;
  assign clr_los_ok = wr_stb_i & wr_data_i.clr_los & ~los_i;
  assign clr_dpm_ok = wr_stb_i & wr_data_i.clr_dpm & ~dpm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      los_chg_o <= 1'b0;
      dpm_chg_o <= 1'b0;
      rst_cmd_o <= 1'b0;
    end else if (reset_req) begin
      ctrl_o    <= '0;
      los_chg_o <= 1'b0;
      dpm_chg_o <= 1'b0;
      rst_cmd_o <= 1'b1;
    end else begin
      rst_cmd_o <= 1'b0;
      if (wr_stb_i) ctrl_o <= wr_data_i;
      los_chg_o <= los_tog_i | (los_chg_o & ~clr_los_ok);
      dpm_chg_o <= dpm_tog_i | (dpm_chg_o & ~clr_dpm_ok);
    end
  end
endmodule

// File: rtl/xcp_ctrl_port.sv
module xcp_ctrl_port
  import xcp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic            clke_i,
  input  logic            los_i,
  input  logic            dpm_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic            irq_no,
  output logic [EQ_W-1:0] eq_code_o,
  output logic            rloop_o,
  output logic            lloop_o,
  output logic            taos_o,
  output logic            rst_cmd_o
);
  logic cs_q, sclk_q, sdi_q, los_q, dpm_q;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic los_rise, los_fall, dpm_rise, dpm_fall;
  logic wr_stb, los_chg, dpm_chg;
  logic [DAT_W-1:0] wr_data, rd_byte;
  ctrl_reg_t ctrl;

  xcp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync_ser (
    .clk_i, .rst_ni, .d_i({cs_ni, sclk_i, sdi_i}), .q_o({cs_q, sclk_q, sdi_q}));

  xcp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_alm (
    .clk_i, .rst_ni, .d_i({los_i, dpm_i}), .q_o({los_q, dpm_q}));

  xcp_edge #(.WIDTH(2), .RST_VAL(2'b10)) u_edge_ser (
    .clk_i, .rst_ni, .d_i({cs_q, sclk_q}),
    .rise_o({cs_rise, sclk_rise}), .fall_o({cs_fall, sclk_fall}));

  xcp_edge #(.WIDTH(2), .RST_VAL(2'b00)) u_edge_alm (
    .clk_i, .rst_ni, .d_i({los_q, dpm_q}),
    .rise_o({los_rise, dpm_rise}), .fall_o({los_fall, dpm_fall}));

  xcp_frame u_frame (
    .clk_i, .rst_ni,
    .cs_i(cs_q), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .sdi_i(sdi_q), .clke_i,
    .rd_byte_i(rd_byte),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .sdo_o, .sdo_oe_o);

  xcp_regs u_regs (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_data_i(ctrl_reg_t'(wr_data)),
    .los_i(los_q), .dpm_i(dpm_q),
    .los_tog_i(los_rise | los_fall), .dpm_tog_i(dpm_rise | dpm_fall),
    .ctrl_o(ctrl), .los_chg_o(los_chg), .dpm_chg_o(dpm_chg),
    .rst_cmd_o);

  assign eq_code_o = ctrl.eq;
  assign rloop_o   = ctrl.rloop;
  assign lloop_o   = ctrl.lloop;
  assign taos_o    = ctrl.taos & ~ctrl.rloop;
  assign irq_no    = ~(los_chg | dpm_chg);
  assign rd_byte   = {status_code(los_chg, dpm_chg, ctrl.rloop, ctrl.lloop, taos_o),
                      ctrl.eq, ctrl.clr_dpm, ctrl.clr_los};
endmodule

// File: rtl/xcp_port_chk.sv
module xcp_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_q,
  input logic       wr_stb,
  input logic       sdo_oe_o,
  input logic       irq_no,
  input logic [2:0] eq_code_o,
  input logic       rloop_o,
  input logic       lloop_o,
  input logic       taos_o,
  input logic       rst_cmd_o
);
  AST_TAOS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rloop_o |-> !taos_o);  // R3
  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |=> !sdo_oe_o);  // R8
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> !sdo_oe_o);  // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !wr_stb) |=> !irq_no);  // R9
  AST_RST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |-> (eq_code_o == 3'd0 && !rloop_o && !lloop_o && !taos_o && irq_no));  // R4
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_o |=> !rst_cmd_o);  // R4
endmodule

bind xcp_ctrl_port xcp_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .wr_stb(wr_stb),
  .sdo_oe_o(sdo_oe_o), .irq_no(irq_no), .eq_code_o(eq_code_o),
  .rloop_o(rloop_o), .lloop_o(lloop_o), .taos_o(taos_o), .rst_cmd_o(rst_cmd_o));

// File: tb/sim_xcp_ctrl_port.sv
module sim_xcp_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [7:0] C_WR = 8'h20, C_RD = 8'h21, C_WR_NS = 8'h00, C_RD_NS = 8'h01;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, sdi = 0, clke = 0, los = 0, dpm = 0;
  logic sdo, sdo_oe, irq_n, rloop, lloop, taos, rst_cmd;
  logic [2:0] eq;
  int n_chk = 0, n_err = 0, n_rst = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_cmd) n_rst++;

  xcp_ctrl_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .clke_i(clke), .los_i(los), .dpm_i(dpm), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .irq_no(irq_n), .eq_code_o(eq), .rloop_o(rloop), .lloop_o(lloop),
    .taos_o(taos), .rst_cmd_o(rst_cmd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input logic ck,
                      input int nbits, output logic [7:0] rd, output logic oe_seen);
    rd = '0; oe_seen = 0;
    @(negedge clk); clke = ck; cs_n = 0; wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? cmd[i] : dat[i-8];
      wait_clk(HALF);
      if (i >= 8) begin
        oe_seen |= sdo_oe;
        if (ck) rd[i-8] = sdo;
      end
      sclk = 1;
      wait_clk(HALF);
      if (i >= 8) oe_seen |= sdo_oe;
      if (!ck && i >= 7 && i <= 14) rd[i-7] = sdo;
      sclk = 0;
    end
    wait_clk(HALF); cs_n = 1; wait_clk(2*HALF);
  endtask

  task automatic wr(input logic [7:0] dat, output logic oe_seen);
    logic [7:0] d;
    xfer(C_WR, dat, 0, 16, d, oe_seen);
  endtask

  task automatic rd_chk(input string tag, input logic ck, input logic [7:0] exp);
    logic [7:0] d; logic oe;
    xfer(C_RD, 8'h00, ck, 16, d, oe);
    chk({tag, " read data"}, d, exp);
    chk({tag, " oe during read"}, oe, 1);
  endtask

  task automatic t_reset;
    chk("R11 eq", eq, 0); chk("R11 loops", {rloop, lloop, taos}, 0);
    chk("R11 irq", irq_n, 1); chk("R11 oe", sdo_oe, 0); chk("R11 rst_cmd", rst_cmd, 0);
  endtask

  task automatic t_write;
    logic oe;
    wr(8'hD4, oe);  // taos=1 lloop=1 rloop=0 eq=5
    chk("R2 eq", eq, 3'd5);
    chk("R2 loops/taos", {rloop, lloop, taos}, 3'b011);
    chk("R8 oe during write", oe, 0);
  endtask

  task automatic t_read;
    rd_chk("R5 R6 R7 clke0", 0, 8'h74);
    rd_chk("R5 R6 R7 clke1", 1, 8'h74);
  endtask

  task automatic t_deselect;
    logic [7:0] d; logic oe;
    xfer(C_WR_NS, 8'h08, 0, 16, d, oe);
    chk("R1 unselected write eq", eq, 3'd5);
    chk("R1 unselected write loops", {rloop, lloop, taos}, 3'b011);
    xfer(C_RD_NS, 8'h00, 0, 16, d, oe);
    chk("R1 R8 unselected read oe", oe, 0);
  endtask

  task automatic t_abort;
    logic [7:0] d; logic oe;
    xfer(C_WR, 8'h08, 0, 12, d, oe);
    chk("R2 aborted write eq", eq, 3'd5);
    chk("R2 aborted write loops", {rloop, lloop, taos}, 3'b011);
  endtask

  task automatic t_rloop;
    logic oe;
    wr(8'hA8, oe);  // taos=1 rloop=1 eq=2
    chk("R3 taos gated", taos, 0);
    chk("R2 rloop set", {rloop, lloop, eq}, {2'b10, 3'd2});
    rd_chk("R6 rloop status", 0, 8'h88);
  endtask

  task automatic t_alarm;
    logic oe;
    los = 1; wait_clk(6);
    chk("R9 irq on los change", irq_n, 0);
    rd_chk("R6 los status", 1, 8'hC8);
    wr(8'hA9, oe);
    chk("R10 clear refused while los high", irq_n, 0);
    los = 0; wait_clk(6);
    wr(8'hA9, oe);
    chk("R10 clear accepted after los low", irq_n, 1);
    dpm = 1; wait_clk(6);
    chk("R9 irq on dpm change", irq_n, 0);
    rd_chk("R6 dpm status", 0, 8'hA9);
    los = 1; wait_clk(6);
    rd_chk("R6 both status", 1, 8'hE9);
    wr(8'hAB, oe);
    chk("R10 both refused", irq_n, 0);
    los = 0; dpm = 0; wait_clk(6);
    wr(8'hAB, oe);
    chk("R9 R10 both cleared", irq_n, 1);
    rd_chk("R6 back to rloop status", 0, 8'h8B);
  endtask

  task automatic t_reset_cmd;
    logic oe;
    los = 1; wait_clk(6);
    chk("R9 irq before reset cmd", irq_n, 0);
    n_rst = 0;
    wr(8'h64, oe);
    chk("R4 rst pulse count", n_rst, 1);
    chk("R4 eq cleared", eq, 0);
    chk("R4 modes cleared", {rloop, lloop, taos}, 0);
    chk("R4 irq released", irq_n, 1);
    rd_chk("R4 R6 status zero", 1, 8'h00);
  endtask

  initial begin
    wait_clk(5); rst_n = 1; wait_clk(5);
    t_reset();
    t_write();
    t_read();
    t_deselect();
    t_abort();
    t_rloop();
    t_alarm();
    t_reset_cmd();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule